// File: doc/BRIEF.md
# Output-Only Console Serial Port Stub

This block is a register-level stand-in for a 16550-style serial port. It provides only what a simple console driver needs to print text. It sits behind a memory-mapped bus port. Each cycle it may take one request made of an address, a byte count, a write flag, an access kind and write data. One cycle later it returns exactly one response. The response carries read data, a fault flag and a fault class. When a write to the transmit data register is accepted, the block pulses a byte-wide strobe towards a console sink.

Baud-rate programming, receive, FIFOs and interrupts are not modelled. Configuration writes are acknowledged and then dropped. The line-status register always reports an empty transmitter, so a polling driver never stalls. A divisor-latch flag, set through the line control register, mutes console output while the driver programs the baud rate. Any read other than the line-status read faults, and the fault class follows the access kind.

The register offset is the bus address minus the parameter `BASE`, computed modulo 2^ADDR_W. The offset decode is: transmit data at 0x00, line control at 0x0C and line status at 0x14.

Top module: `console_uart_stub`

## Requirements
- R1: After reset `rsp_valid` and `tx_valid` are 0 and the divisor-latch flag is 0, so the first 4-byte data-register write emits its byte.
- R2: A read with `req_size` = 4 at offset 0x14 returns 0x20 (bit 5, transmitter empty), zero-extended to DATA_W, with `rsp_fault` = 0, whatever the access kind.
- R3: Every other read sets `rsp_fault` = 1 with `rsp_rdata` = 0. The access kind is encoded as fetch = 0, load = 1, store = 2 and AMO = 3. The fault class is 0 (instruction) for a fetch, 1 (load) for a load, and 2 (store/AMO) for a store or an AMO.
- R4: A write with `req_size` 4 or 8 at offset 0x0C loads bit 7 of `req_wdata` into the divisor-latch flag. No other request changes the flag.
- R5: A write with `req_size` 4 or 8 at offset 0x00 while the flag is 0 raises `tx_valid` for one cycle, together with its response. `tx_byte` then holds `req_wdata[7:0]`.
- R6: While the flag is 1, a data-register write is acknowledged without fault and does not raise `tx_valid`.
- R7: A write to any other offset, or with a byte count other than 4 or 8, completes without fault. It changes neither the flag nor the console output.
- R8: Every accepted request (`req_valid` = 1) gives exactly one response (`rsp_valid` = 1) in the next cycle. No response appears without a request. Back-to-back requests are served every cycle.
- R9: Decoding is relative to `BASE`. An address below `BASE` wraps to a large offset and is treated as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 AMO |
| req_addr | input | ADDR_W | Bus address |
| req_size | input | 4 | Access width in bytes |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W | Read data |
| rsp_fault | output | 1 | Access fault |
| rsp_fault_kind | output | 2 | Fault class: 0 instruction, 1 load, 2 store/AMO |
| tx_valid | output | 1 | Console byte strobe |
| tx_byte | output | 8 | Console byte |

## Verification
The hardest state to reach is a muted data write that falls between two changes of the divisor-latch flag. The flag cannot be read back, so it can only be inferred from whether later data writes produce output. The stimulus therefore sets the flag and sends a data write, expecting no output. It then attempts a narrow-width line-control write that must leave the flag set, and follows with another muted data write. Next it clears the flag with an 8-byte write and checks that output resumes. Finally it sets the flag again and applies a mid-run reset, showing that output returns afterwards.

// File: rtl/console_uart_pkg.sv
package console_uart_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_AMO   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_INSN  = 2'd0,
    FLT_LOAD  = 2'd1,
    FLT_STORE = 2'd2
  } fault_kind_e;

  localparam int unsigned SIZE_W     = 4;
  localparam int unsigned OFF_TXDATA = 'h00;
  localparam int unsigned OFF_LINECTL = 'h0C;
  localparam int unsigned OFF_LINESTS = 'h14;
  localparam logic [7:0]  STATUS_VAL = 8'h20;
  localparam int unsigned LATCH_BIT  = 7;

  // Fault class chosen by the access kind of a refused read.
  function automatic fault_kind_e fault_for(input logic [1:0] kind);
    case (kind)
      ACC_FETCH: fault_for = FLT_INSN;
      ACC_LOAD:  fault_for = FLT_LOAD;
      default:   fault_for = FLT_STORE;
    endcase
  endfunction

  // Register writes accept word and double-word accesses only.
  function automatic logic wide_write(input logic [SIZE_W-1:0] size);
    wide_write = (size == SIZE_W'(4)) || (size == SIZE_W'(8));
  endfunction

  // The status read is defined for a 4-byte access only.
  function automatic logic status_size(input logic [SIZE_W-1:0] size);
    status_size = (size == SIZE_W'(4));
  endfunction

endpackage

// File: rtl/cuart_decode.sv
module cuart_decode
  import console_uart_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              status_rd_hit,
  output logic              data_wr_hit,
  output logic              ctl_wr_hit,
  output logic              read_refused
);

  localparam logic [ADDR_W-1:0] O_DATA = ADDR_W'(OFF_TXDATA);
  localparam logic [ADDR_W-1:0] O_CTL  = ADDR_W'(OFF_LINECTL);
  localparam logic [ADDR_W-1:0] O_STS  = ADDR_W'(OFF_LINESTS);

  logic [ADDR_W-1:0] offset;
  logic              is_rd;
  logic              is_wr;

  always_comb begin
    offset        = req_addr - BASE;
    is_rd         = req_valid && !req_write;
    is_wr         = req_valid && req_write;
    status_rd_hit = is_rd && (offset == O_STS) && status_size(req_size);
    data_wr_hit   = is_wr && (offset == O_DATA) && wide_write(req_size);
    ctl_wr_hit    = is_wr && (offset == O_CTL) && wide_write(req_size);
    read_refused  = is_rd && !status_rd_hit;
  end

endmodule

// File: rtl/cuart_latch_flag.sv
module cuart_latch_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr_hit,
  input  logic latch_bit,
  output logic dlab_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlab_q <= 1'b0;
    end else if (ctl_wr_hit) begin
      dlab_q <= latch_bit;
    end
  end

endmodule

// File: rtl/cuart_respond.sv
module cuart_respond
  import console_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [7:0]        wbyte,
  input  logic              status_rd_hit,
  input  logic              read_refused,
  input  logic              tx_fire,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_fault,
  output logic [1:0]        rsp_fault_kind,
  output logic              tx_valid,
  output logic [7:0]        tx_byte
);

  logic [DATA_W-1:0] rdata_d;
  logic [1:0]        fkind_d;
  logic [7:0]        byte_d;

  always_comb begin
    rdata_d = status_rd_hit ? DATA_W'(STATUS_VAL) : '0;
    fkind_d = read_refused ? 2'(fault_for(req_kind)) : 2'd0;
    byte_d  = tx_fire ? wbyte : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      rsp_fault      <= 1'b0;
      rsp_fault_kind <= 2'd0;
      tx_valid       <= 1'b0;
      tx_byte        <= 8'h00;
    end else begin
      rsp_valid      <= req_valid;
      rsp_rdata      <= rdata_d;
      rsp_fault      <= read_refused;
      rsp_fault_kind <= fkind_d;
      tx_valid       <= tx_fire;
      tx_byte        <= byte_d;
    end
  end

endmodule

// File: rtl/console_uart_stub.sv
module console_uart_stub
  import console_uart_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter logic [ADDR_W-1:0] BASE = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_fault,
  output logic [1:0]        rsp_fault_kind,
  output logic              tx_valid,
  output logic [7:0]        tx_byte
);

  // Named internal events, also observed by the bound checker.
  logic status_rd_hit;
  logic data_wr_hit;
  logic ctl_wr_hit;
  logic read_refused;
  logic dlab_q;
  logic tx_fire;

  cuart_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .status_rd_hit (status_rd_hit),
    .data_wr_hit   (data_wr_hit),
    .ctl_wr_hit    (ctl_wr_hit),
    .read_refused  (read_refused)
  );

  cuart_latch_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_hit (ctl_wr_hit),
    .latch_bit  (req_wdata[LATCH_BIT]),
    .dlab_q     (dlab_q)
  );

  assign tx_fire = data_wr_hit && !dlab_q;

  cuart_respond #(.DATA_W(DATA_W)) u_resp (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .wbyte          (req_wdata[7:0]),
    .status_rd_hit  (status_rd_hit),
    .read_refused   (read_refused),
    .tx_fire        (tx_fire),
    .rsp_valid      (rsp_valid),
    .rsp_rdata      (rsp_rdata),
    .rsp_fault      (rsp_fault),
    .rsp_fault_kind (rsp_fault_kind),
    .tx_valid       (tx_valid),
    .tx_byte        (tx_byte)
  );

endmodule

// File: rtl/cuart_checker.sv
module cuart_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [7:0]        req_lo,
  input logic              data_wr_hit,
  input logic              ctl_wr_hit,
  input logic              dlab_q,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_fault,
  input logic              tx_valid,
  input logic [7:0]        tx_byte
);

  // R8
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R7
  write_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_fault);

  // R4
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_hit |=> (dlab_q == $past(req_lo[7])));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_hit |=> $stable(dlab_q));

  // R5
  tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_hit && !dlab_q) |=> (tx_valid && tx_byte == $past(req_lo)));

  // R6
  tx_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_hit && dlab_q) |=> !tx_valid);

  // R5
  tx_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (rsp_valid && !rsp_fault));

  // R3
  fault_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_rdata == '0));

endmodule

bind console_uart_stub cuart_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_lo      (req_wdata[7:0]),
  .data_wr_hit (data_wr_hit),
  .ctl_wr_hit  (ctl_wr_hit),
  .dlab_q      (dlab_q),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_fault   (rsp_fault),
  .tx_valid    (tx_valid),
  .tx_byte     (tx_byte)
);

// File: tb/console_uart_stub_test.sv
`timescale 1ns/1ps
module console_uart_stub_test;

  localparam int unsigned AW = 32;
  localparam int unsigned DW = 64;
  localparam logic [AW-1:0] BASE = 32'h1000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_kind = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_size = 4'd0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_fault;
  logic [1:0]    rsp_fault_kind;
  logic          tx_valid;
  logic [7:0]    tx_byte;

  always #2.5 clk = ~clk;

  console_uart_stub #(.ADDR_W(AW), .DATA_W(DW), .BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_kind(req_kind), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_fault(rsp_fault), .rsp_fault_kind(rsp_fault_kind),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  typedef struct {
    logic [DW-1:0] rdata;
    logic          fault;
    logic [1:0]    fkind;
    logic          tx;
    logic [7:0]    txb;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: present one request for one cycle and queue its expected response.
  task automatic send(input bit wr, input logic [1:0] kind, input logic [AW-1:0] addr,
                      input logic [3:0] size, input logic [DW-1:0] wdata,
                      input logic [DW-1:0] e_rdata, input bit e_fault, input logic [1:0] e_fk,
                      input bit e_tx, input logic [7:0] e_txb, input string tag);
    exp_t e;
    e.rdata = e_rdata; e.fault = e_fault; e.fkind = e_fk;
    e.tx = e_tx; e.txb = e_txb; e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_kind = kind;
    req_addr = addr; req_size = size; req_wdata = wdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0; req_write = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare each response and console strobe against the queue.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "response without request", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_rdata == e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
          check(rsp_fault == e.fault, e.tag, "fault", DW'(rsp_fault), DW'(e.fault));
          check(rsp_fault_kind == e.fkind, e.tag, "fault kind", DW'(rsp_fault_kind), DW'(e.fkind));
          check(tx_valid == e.tx, e.tag, "tx strobe", DW'(tx_valid), DW'(e.tx));
          if (e.tx) check(tx_byte == e.txb, e.tag, "tx byte", DW'(tx_byte), DW'(e.txb));
        end
      end else if (tx_valid) begin
        check(1'b0, "R5", "strobe without response", 1, 0);
      end
    end
  end

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    check(1'b0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  localparam logic [AW-1:0] A_DATA = BASE + 32'h00;
  localparam logic [AW-1:0] A_CTL  = BASE + 32'h0C;
  localparam logic [AW-1:0] A_STS  = BASE + 32'h14;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", DW'(rsp_valid), 0);
    check(tx_valid == 1'b0, "R1", "tx_valid in reset", DW'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8", "idle response", DW'(rsp_valid), 0);

    // R1/R5: flag starts at 0, first data write prints
    send(1, 2'd2, A_DATA, 4'd4, 64'hDEAD_BEEF_0000_1141, 0, 0, 2'd0, 1, 8'h41, "R1");
    send(1, 2'd2, A_DATA, 4'd8, 64'hFFFF_FFFF_FFFF_FF42, 0, 0, 2'd0, 1, 8'h42, "R5");
    send(1, 2'd2, A_DATA, 4'd4, 64'h0000_0000_0000_0A43, 0, 0, 2'd0, 1, 8'h43, "R5");
    idle(2);

    // R2 status read, several access kinds
    send(0, 2'd1, A_STS, 4'd4, 0, 64'h20, 0, 2'd0, 0, 0, "R2");
    send(0, 2'd0, A_STS, 4'd4, 0, 64'h20, 0, 2'd0, 0, 0, "R2");
    // R3 refused reads by kind
    send(0, 2'd1, A_STS, 4'd8, 0, 0, 1, 2'd1, 0, 0, "R3");
    send(0, 2'd0, A_DATA, 4'd4, 0, 0, 1, 2'd0, 0, 0, "R3");
    send(0, 2'd2, A_CTL, 4'd4, 0, 0, 1, 2'd2, 0, 0, "R3");
    send(0, 2'd3, A_STS, 4'd1, 0, 0, 1, 2'd2, 0, 0, "R3");
    idle(1);

    // R4 set flag, R6 muted data write
    send(1, 2'd2, A_CTL, 4'd4, 64'h83, 0, 0, 2'd0, 0, 0, "R4");
    send(1, 2'd2, A_DATA, 4'd4, 64'h44, 0, 0, 2'd0, 0, 0, "R6");
    // R7 narrow control write must not clear flag
    send(1, 2'd2, A_CTL, 4'd1, 64'h00, 0, 0, 2'd0, 0, 0, "R7");
    send(1, 2'd2, A_CTL, 4'd2, 64'h00, 0, 0, 2'd0, 0, 0, "R7");
    send(1, 2'd2, A_DATA, 4'd8, 64'h45, 0, 0, 2'd0, 0, 0, "R6");
    // R4 clear flag with 8-byte write, output resumes
    send(1, 2'd2, A_CTL, 4'd8, 64'hFFFF_FF03, 0, 0, 2'd0, 0, 0, "R4");
    send(1, 2'd2, A_DATA, 4'd4, 64'h46, 0, 0, 2'd0, 1, 8'h46, "R4");
    idle(1);

    // R7 ignored writes: other offsets, narrow data writes
    send(1, 2'd2, A_STS, 4'd4, 64'h80, 0, 0, 2'd0, 0, 0, "R7");
    send(1, 2'd2, BASE + 32'h08, 4'd4, 64'h80, 0, 0, 2'd0, 0, 0, "R7");
    send(1, 2'd2, A_DATA, 4'd2, 64'h47, 0, 0, 2'd0, 0, 0, "R7");
    send(1, 2'd2, A_DATA, 4'd1, 64'h48, 0, 0, 2'd0, 0, 0, "R7");
    send(1, 2'd2, A_DATA, 4'd4, 64'h49, 0, 0, 2'd0, 1, 8'h49, "R7");

    // R9 base-relative decode
    send(0, 2'd1, BASE - 32'h4, 4'd4, 0, 0, 1, 2'd1, 0, 0, "R9");
    send(0, 2'd1, 32'h0000_0014, 4'd4, 0, 0, 1, 2'd1, 0, 0, "R9");
    send(1, 2'd2, 32'h0000_0000, 4'd4, 64'h4A, 0, 0, 2'd0, 0, 0, "R9");
    idle(2);

    // R1 mid-run reset clears the flag
    send(1, 2'd2, A_CTL, 4'd4, 64'h80, 0, 0, 2'd0, 0, 0, "R4");
    idle(2);
    rst_n = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0 && tx_valid == 1'b0, "R1", "outputs in reset",
          DW'({rsp_valid, tx_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send(1, 2'd2, A_DATA, 4'd4, 64'h4B, 0, 0, 2'd0, 1, 8'h4B, "R1");
    idle(3);

    check(exp_q.size() == 0, "R8", "responses outstanding", DW'(exp_q.size()), 0);
    finish_run();
  end

endmodule